// File: doc/BRIEF.md
# Time-Slot Classified Transmit Multiplexer

This block sits between a bank of transmit byte queues and the serializer of a framed TDM link. Each time the serializer asks for the byte of its next time slot, the block works out which slot that is. It reads that slot's class and HDLC channel from a software-written table, and supplies the byte from the matching queue. The queues are a voice queue plus one queue per HDLC channel, five in all by default. The queues sit outside the block and present their head byte in show-ahead form.

Slots marked unused take nothing from any queue and carry the idle pattern. Slots in the reduced-rate voice class draw from the voice queue and force the byte's low bit high. When the selected queue has nothing to give, the idle pattern goes out instead and a sticky per-queue underrun flag records the starvation. Software clears the flag with a write-one pulse.

Top module: `tdm_slot_tx_mux`

## Requirements
- R1: While reset is held and after it is released, `tx_valid`, `fifo_pop` and `underrun` are all zero. Every table entry starts as class unused.
- R2: A `byte_req` pulse sampled on a clock edge produces `tx_valid` high for exactly the following cycle. Any `fifo_pop` happens only in that cycle.
- R3: The slot a request serves is 0 if `fsync` is high with it; otherwise it is one past the previous request's slot. After the slot `slots_per_frame`-1 (or the last table entry) the count wraps to 0. An `fsync` without a request makes the next request slot 0. `tx_slot` shows the served slot while `tx_valid` is high.
- R4: In a slot of class voice (code 2), queue 0 is popped and its head byte appears unchanged on `tx_byte`.
- R5: In a slot of class HDLC (code 1), queue 1+c is popped, where c is the channel field of that slot's table entry. Its head byte is sent unchanged.
- R6: In a slot of class voice-56 (code 3), queue 0 is popped and its head byte is sent with bit 0 forced to 1.
- R7: In a slot of class unused (code 0), no queue is popped and `tx_byte` is 0xFF. `tx_byte` is also 0xFF whenever `tx_valid` is low.
- R8: If the queue a slot selects is empty, that queue is not popped, 0xFF is sent, and `underrun` bit i is set on the next edge. Bit i is the index of that queue.
- R9: An `underrun` bit stays set until a cycle in which its `ud_clr` bit is 1. A new underrun in that same cycle keeps the bit set.
- R10: At most one queue is popped per cycle. A table write on the same edge as a request applies to that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_req | input | 1 | Serializer asks for the next slot's byte |
| fsync | input | 1 | Frame start; restarts slot numbering |
| slots_per_frame | input | SLOT_W+1 | Number of slots in a frame |
| tbl_we | input | 1 | Table write strobe |
| tbl_slot | input | SLOT_W | Table entry to write |
| tbl_class | input | 2 | Class code: 0 unused, 1 HDLC, 2 voice, 3 voice-56 |
| tbl_chan | input | CHAN_W | HDLC channel of the entry |
| fifo_empty | input | NFIFO | Per-queue empty flags (0 voice, 1+c HDLC channel c) |
| fifo_data | input | NFIFO*DATA_W | Head bytes, queue i at bits i*DATA_W upward |
| fifo_pop | output | NFIFO | Pop strobe per queue |
| ud_clr | input | NFIFO | Write-one clear of underrun flags |
| tx_valid | output | 1 | Byte for the serializer is valid |
| tx_byte | output | DATA_W | Byte to serialize |
| tx_slot | output | SLOT_W | Slot served by the current byte |
| underrun | output | NFIFO | Sticky starvation flags per queue |

## Verification
The bench goes after the frame edges. Among them are a request with `fsync` on the same edge, a lone `fsync` in mid-frame, and a frame length of zero. A counter that mishandled any of these would shift every later byte to the wrong queue. It drains an HDLC queue and keeps asking for it, which a design that popped an empty queue or sent stale data would fail. It also lands a clear on the same edge as a fresh underrun, where a design that let the clear win would lose the event. Table writes aimed at the slot being requested catch a one-cycle-late lookup. A long random run mixes classes, channels and gaps between requests.

// File: rtl/tdm_txmux_pkg.sv
package tdm_txmux_pkg;
   typedef enum logic [1:0] {
      CLS_UNUSED  = 2'd0,
      CLS_PACKET  = 2'd1,
      CLS_VOICE   = 2'd2,
      CLS_VOICE56 = 2'd3
   } slot_class_e;

   localparam int VOICE_Q = 0;
endpackage

// File: rtl/txmux_slot_counter.sv
module txmux_slot_counter #(
   parameter int MAX_SLOTS = 32,
   parameter int SLOT_W    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_req,
   input  logic              fsync,
   input  logic [SLOT_W:0]   slots_per_frame,
   output logic              req_q,
   output logic [SLOT_W-1:0] slot_q
);
   logic [SLOT_W-1:0] cnt_q;
   logic [SLOT_W-1:0] used;
   logic [SLOT_W:0]   next_w;
   logic              wrap;

   always_comb begin
      used   = fsync ? '0 : cnt_q;
      next_w = {1'b0, used} + 1'b1;
      wrap   = (next_w >= slots_per_frame) || (used == SLOT_W'(MAX_SLOTS - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         req_q  <= 1'b0;
         slot_q <= '0;
      end else begin
         req_q <= byte_req;
         if (byte_req) begin
            slot_q <= used;
            cnt_q  <= wrap ? '0 : next_w[SLOT_W-1:0];
         end else if (fsync) begin
            cnt_q <= '0;
         end
      end
   end
endmodule

// File: rtl/txmux_slot_table.sv
module txmux_slot_table
   import tdm_txmux_pkg::*;
#(
   parameter int MAX_SLOTS = 32,
   parameter int SLOT_W    = 5,
   parameter int CHAN_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  slot_class_e       wr_class,
   input  logic [CHAN_W-1:0] wr_chan,
   input  logic [SLOT_W-1:0] rd_slot,
   output slot_class_e       rd_class,
   output logic [CHAN_W-1:0] rd_chan
);
   slot_class_e       cls_q  [MAX_SLOTS];
   logic [CHAN_W-1:0] chan_q [MAX_SLOTS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < MAX_SLOTS; i++) begin
            cls_q[i]  <= CLS_UNUSED;
            chan_q[i] <= '0;
         end
      end else if (wr_en && (int'(wr_slot) < MAX_SLOTS)) begin
         cls_q[wr_slot]  <= wr_class;
         chan_q[wr_slot] <= wr_chan;
      end
   end

   always_comb begin
      rd_class = CLS_UNUSED;
      rd_chan  = '0;
      if (int'(rd_slot) < MAX_SLOTS) begin
         rd_class = cls_q[rd_slot];
         rd_chan  = chan_q[rd_slot];
      end
   end
endmodule

// File: rtl/txmux_fifo_sel.sv
module txmux_fifo_sel
   import tdm_txmux_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int HDLC_CH = 4,
   parameter int CHAN_W  = 2,
   parameter int NFIFO   = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    slot_valid,
   input  slot_class_e             slot_cls,
   input  logic [CHAN_W-1:0]       slot_chan,
   input  logic [NFIFO-1:0]        fifo_empty,
   input  logic [NFIFO*DATA_W-1:0] fifo_data,
   input  logic [NFIFO-1:0]        ud_clr,
   output logic [NFIFO-1:0]        fifo_pop,
   output logic [DATA_W-1:0]       tx_byte,
   output logic [NFIFO-1:0]        underrun
);
   localparam logic [DATA_W-1:0] IDLE_BYTE = '1;
   localparam logic [DATA_W-1:0] LSB_ONE   = DATA_W'(1);

   logic [NFIFO-1:0]  want;
   logic [NFIFO-1:0]  starve;
   logic [DATA_W-1:0] pick [NFIFO];
   logic [DATA_W-1:0] head;

   always_comb begin
      want = '0;
      if (slot_valid) begin
         case (slot_cls)
            CLS_VOICE, CLS_VOICE56: want[VOICE_Q] = 1'b1;
            CLS_PACKET: begin
               for (int k = 0; k < HDLC_CH; k++)
                  if (slot_chan == CHAN_W'(k)) want[1+k] = 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign fifo_pop = want & ~fifo_empty;
   assign starve   = want & fifo_empty;

   for (genvar g = 0; g < NFIFO; g++) begin : g_q
      assign pick[g] = fifo_pop[g] ? fifo_data[g*DATA_W +: DATA_W] : '0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         underrun[g] <= 1'b0;
         else if (starve[g]) underrun[g] <= 1'b1;
         else if (ud_clr[g]) underrun[g] <= 1'b0;
      end
   end

   always_comb begin
      head = '0;
      for (int i = 0; i < NFIFO; i++) head |= pick[i];
      if (fifo_pop == '0)              tx_byte = IDLE_BYTE;
      else if (slot_cls == CLS_VOICE56) tx_byte = head | LSB_ONE;
      else                             tx_byte = head;
   end
endmodule

// File: rtl/tdm_slot_tx_mux.sv
module tdm_slot_tx_mux
   import tdm_txmux_pkg::*;
#(
   parameter int  DATA_W    = 8,
   parameter int  MAX_SLOTS = 32,
   parameter int  HDLC_CH   = 4,
   localparam int SLOT_W    = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
   localparam int CHAN_W    = (HDLC_CH > 1) ? $clog2(HDLC_CH) : 1,
   localparam int NFIFO     = HDLC_CH + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    byte_req,
   input  logic                    fsync,
   input  logic [SLOT_W:0]         slots_per_frame,
   input  logic                    tbl_we,
   input  logic [SLOT_W-1:0]       tbl_slot,
   input  logic [1:0]              tbl_class,
   input  logic [CHAN_W-1:0]       tbl_chan,
   input  logic [NFIFO-1:0]        fifo_empty,
   input  logic [NFIFO*DATA_W-1:0] fifo_data,
   output logic [NFIFO-1:0]        fifo_pop,
   input  logic [NFIFO-1:0]        ud_clr,
   output logic                    tx_valid,
   output logic [DATA_W-1:0]       tx_byte,
   output logic [SLOT_W-1:0]       tx_slot,
   output logic [NFIFO-1:0]        underrun
);
   if (DATA_W < 2) begin : g_bad_width
      $error("tdm_slot_tx_mux: DATA_W must be at least 2");
   end
   if (MAX_SLOTS < 2) begin : g_bad_slots
      $error("tdm_slot_tx_mux: MAX_SLOTS must be at least 2");
   end
   if (HDLC_CH < 1) begin : g_bad_chan
      $error("tdm_slot_tx_mux: HDLC_CH must be at least 1");
   end

   logic              req_q;
   logic [SLOT_W-1:0] slot_q;
   slot_class_e       cur_cls;
   logic [CHAN_W-1:0] cur_chan;

   txmux_slot_counter #(.MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .byte_req(byte_req), .fsync(fsync),
      .slots_per_frame(slots_per_frame), .req_q(req_q), .slot_q(slot_q)
   );

   txmux_slot_table #(.MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W), .CHAN_W(CHAN_W)) u_tbl (
      .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_slot(tbl_slot),
      .wr_class(slot_class_e'(tbl_class)), .wr_chan(tbl_chan),
      .rd_slot(slot_q), .rd_class(cur_cls), .rd_chan(cur_chan)
   );

   txmux_fifo_sel #(.DATA_W(DATA_W), .HDLC_CH(HDLC_CH), .CHAN_W(CHAN_W), .NFIFO(NFIFO)) u_sel (
      .clk(clk), .rst_n(rst_n), .slot_valid(req_q), .slot_cls(cur_cls),
      .slot_chan(cur_chan), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
      .ud_clr(ud_clr), .fifo_pop(fifo_pop), .tx_byte(tx_byte), .underrun(underrun)
   );

   assign tx_valid = req_q;
   assign tx_slot  = slot_q;
endmodule

// File: rtl/txmux_checker.sv
module txmux_checker #(
   parameter int DATA_W    = 8,
   parameter int MAX_SLOTS = 32,
   parameter int HDLC_CH   = 4
) (
   input logic                                             clk,
   input logic                                             rst_n,
   input logic                                             byte_req,
   input logic                                             fsync,
   input logic                                             tx_valid,
   input logic [((MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1)-1:0] tx_slot,
   input logic [DATA_W-1:0]                                tx_byte,
   input logic [HDLC_CH:0]                                 fifo_pop,
   input logic [HDLC_CH:0]                                 fifo_empty,
   input logic [HDLC_CH:0]                                 underrun,
   input logic [HDLC_CH:0]                                 ud_clr
);
   // R2: the byte strobe follows each request by exactly one cycle
   a_r2_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      byte_req |=> tx_valid);
   a_r2_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_req |=> !tx_valid);
   a_r2_pop_in_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_pop != '0) |-> tx_valid);
   // R3: a request coincident with frame sync serves slot 0
   a_r3_sync_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_req && fsync) |=> (tx_slot == '0));
   // R7: nothing popped means the idle byte goes out
   a_r7_idle_without_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_pop == '0) |-> (tx_byte == '1));
   // R8: an empty queue is never popped
   a_r8_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_pop & fifo_empty) == '0);
   // R9: an underrun bit only falls after its clear pulse
   a_r9_sticky_flags: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(underrun) & ~$past(ud_clr)) & ~underrun) == '0));
   // R10: one queue at most per cycle
   a_r10_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fifo_pop));
   initial begin
      a_r10_width_ok: assert ($bits(fifo_pop) == HDLC_CH + 1);
   end
endmodule

bind tdm_slot_tx_mux txmux_checker #(
   .DATA_W(DATA_W), .MAX_SLOTS(MAX_SLOTS), .HDLC_CH(HDLC_CH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .byte_req(byte_req), .fsync(fsync),
   .tx_valid(tx_valid), .tx_slot(tx_slot), .tx_byte(tx_byte),
   .fifo_pop(fifo_pop), .fifo_empty(fifo_empty), .underrun(underrun),
   .ud_clr(ud_clr)
);

// File: tb/tdm_slot_tx_mux_test.sv
`timescale 1ns/1ps
module tdm_slot_tx_mux_test;
   localparam int DW = 8, MS = 32, HC = 4, NF = 5, SW = 5, CW = 2;

   logic clk = 1'b0, rst_n = 1'b0, byte_req = 1'b0, fsync = 1'b0, tbl_we = 1'b0;
   logic [SW:0]      spf = 6'd4;
   logic [SW-1:0]    tbl_slot = '0;
   logic [1:0]       tbl_class = '0;
   logic [CW-1:0]    tbl_chan = '0;
   logic [NF-1:0]    fifo_empty = '1, ud_clr = '0;
   logic [NF*DW-1:0] fifo_data = '0;
   logic [NF-1:0]    fifo_pop, underrun;
   logic             tx_valid;
   logic [DW-1:0]    tx_byte;
   logic [SW-1:0]    tx_slot;

   always #2.5 clk = ~clk;

   tdm_slot_tx_mux #(.DATA_W(DW), .MAX_SLOTS(MS), .HDLC_CH(HC)) uut (
      .clk(clk), .rst_n(rst_n), .byte_req(byte_req), .fsync(fsync),
      .slots_per_frame(spf), .tbl_we(tbl_we), .tbl_slot(tbl_slot),
      .tbl_class(tbl_class), .tbl_chan(tbl_chan), .fifo_empty(fifo_empty),
      .fifo_data(fifo_data), .fifo_pop(fifo_pop), .ud_clr(ud_clr),
      .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_slot(tx_slot), .underrun(underrun)
   );

   typedef logic [7:0] byteq_t[$];
   byteq_t fq [NF];

   int checks = 0, errors = 0;
   string ph = "R1";
   bit done = 0;
   int m_req = 0, m_slot = 0, m_cnt = 0;
   int tcls [MS];
   int tch  [MS];
   logic [NF-1:0] m_ud = '0;

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s act=%0h exp=%0h", ph, what, act, exp);
      end
   endtask

   task automatic drive_fifos();
      for (int i = 0; i < NF; i++) begin
         fifo_empty[i] = (fq[i].size() == 0);
         fifo_data[i*DW +: DW] = fifo_empty[i] ? 8'h00 : fq[i][0];
      end
   endtask

   task automatic push(int f, logic [7:0] b);
      fq[f].push_back(b);
   endtask

   // one clock: drive at negedge, compare mid-cycle, advance model at posedge
   task automatic cyc(input logic req, input logic fs);
      logic [NF-1:0] ep, es;
      logic [7:0] eb;
      int c, idx, used;
      byte_req = req;
      fsync = fs;
      drive_fifos();
      #1;
      ep = '0; es = '0; eb = 8'hFF;
      if (m_req != 0) begin
         c = tcls[m_slot];
         idx = (c == 1) ? 1 + tch[m_slot] : 0;
         if (c != 0) begin
            if (fq[idx].size() == 0) es[idx] = 1'b1;
            else begin
               ep[idx] = 1'b1;
               eb = fq[idx][0];
               if (c == 3) eb[0] = 1'b1;
            end
         end
      end
      chk("R2 tx_valid", 32'(tx_valid), 32'(m_req));
      chk("fifo_pop", 32'(fifo_pop), 32'(ep));
      chk("tx_byte", 32'(tx_byte), 32'(eb));
      chk("R9 underrun", 32'(underrun), 32'(m_ud));
      if (m_req != 0) chk("R3 tx_slot", 32'(tx_slot), 32'(m_slot));
      @(posedge clk);
      m_ud = (m_ud & ~ud_clr) | es;
      if (tbl_we) begin
         tcls[tbl_slot] = int'(tbl_class);
         tch[tbl_slot]  = int'(tbl_chan);
      end
      for (int i = 0; i < NF; i++) if (ep[i]) void'(fq[i].pop_front());
      if (req) begin
         used = fs ? 0 : m_cnt;
         m_slot = used;
         m_req = 1;
         m_cnt = ((used + 1 >= int'(spf)) || (used == MS - 1)) ? 0 : used + 1;
      end else begin
         m_req = 0;
         if (fs) m_cnt = 0;
      end
      #1;
      drive_fifos();
      @(negedge clk);
      tbl_we = 1'b0;
      ud_clr = '0;
   endtask

   task automatic wtbl(int s, int c, int ch);
      tbl_we = 1'b1;
      tbl_slot = SW'(s);
      tbl_class = 2'(c);
      tbl_chan = CW'(ch);
      cyc(1'b0, 1'b0);
   endtask

   initial begin
      for (int i = 0; i < MS; i++) begin tcls[i] = 0; tch[i] = 0; end
      drive_fifos();
      repeat (3) @(negedge clk);
      ph = "R1 reset";
      chk("R1 tx_valid", 32'(tx_valid), 0);
      chk("R1 fifo_pop", 32'(fifo_pop), 0);
      chk("R1 underrun", 32'(underrun), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: default table is all unused, so a full voice queue is left alone
      ph = "R1 default table";
      push(0, 8'h10);
      cyc(1, 1); cyc(0, 0); cyc(1, 0); cyc(0, 0);

      // slot0 voice, slot1 HDLC channel 2 (queue 3), slot2 unused, slot3 voice-56
      ph = "R10 table setup";
      wtbl(0, 2, 0); wtbl(1, 1, 2); wtbl(2, 0, 0); wtbl(3, 3, 0);
      for (int k = 0; k < 9; k++) push(0, 8'(8'h20 + 2 * k));
      push(3, 8'hA1); push(3, 8'hA2); push(3, 8'hA3);

      // R4 R5 R6 R7 back-to-back frame walk (R2 pipelining)
      ph = "R4 R5 R6 R7 back-to-back";
      for (int k = 0; k < 12; k++) cyc(1, k == 0);
      ph = "R2 gapped requests";
      for (int k = 0; k < 8; k++) cyc(k % 2 == 0, 0);

      // R8: queue 3 is now drained; keep asking for slot 1
      ph = "R8 starved HDLC";
      cyc(1, 1);
      for (int k = 0; k < 7; k++) cyc(1, 0);
      cyc(0, 0);

      // R9: sticky, cleared by pulse, set beats a simultaneous clear
      ph = "R9 sticky clear";
      cyc(0, 0); cyc(0, 0);
      ud_clr = 5'b01000; cyc(0, 0);
      cyc(0, 0);
      cyc(1, 1); cyc(1, 0);
      ud_clr = 5'b01000; cyc(0, 0);
      cyc(0, 0);
      ud_clr = 5'b11111; cyc(0, 0);

      // R3: longer frame, lone fsync, mid-frame fsync, zero-length frame
      ph = "R3 slot counting";
      spf = 6'd6;
      for (int k = 0; k < 8; k++) push(0, 8'(k));
      cyc(0, 1);
      for (int k = 0; k < 14; k++) cyc(1, 0);
      cyc(1, 0); cyc(1, 0); cyc(0, 1); cyc(1, 0); cyc(1, 0); cyc(1, 1); cyc(1, 0);
      spf = 6'd0;
      for (int k = 0; k < 4; k++) cyc(1, 0);
      spf = 6'd32;
      cyc(1, 1);
      for (int k = 0; k < 34; k++) cyc(1, 0);
      spf = 6'd4;

      // R10: table write on the same edge as the request it governs
      ph = "R10 write with request";
      push(1, 8'h5A); push(1, 8'h5B);
      tbl_we = 1'b1; tbl_slot = 5'd0; tbl_class = 2'd1; tbl_chan = 2'd0;
      cyc(1, 1);
      cyc(0, 0);
      tbl_we = 1'b1; tbl_slot = 5'd1; tbl_class = 2'd1; tbl_chan = 2'd0;
      cyc(1, 0);
      cyc(0, 0);

      // R5 R6 R8 R10 random mix of classes, channels and gaps
      ph = "R10 random";
      for (int n = 0; n < 3000; n++) begin
         int f;
         f = $urandom_range(NF - 1);
         if (fq[f].size() < 6 && $urandom_range(2) != 0) push(f, 8'($urandom));
         if ($urandom_range(9) < 2) begin
            tbl_we = 1'b1;
            tbl_slot = 5'($urandom_range(7));
            tbl_class = 2'($urandom);
            tbl_chan = 2'($urandom);
         end
         if ($urandom_range(9) == 0) ud_clr = 5'($urandom);
         if ($urandom_range(199) == 0) spf = 6'($urandom_range(8));
         cyc($urandom_range(9) < 6, $urandom_range(19) == 0);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run hung act=running exp=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule